// File: doc/BRIEF.md
# Memory-Mapped Terminal I/O Controller

This block lets a processor talk to a character keyboard and a character display using only ordinary loads and stores. It answers a fixed 4 KiB page at the top of the address space. Four word registers sit in that page: a status/control word and a data word for each direction. Software can poll the ready flags. It can also set per-direction enable bits and wait on a single level interrupt line.

Characters arrive on a one-cycle valid strobe with a byte. The block holds one character. Reading the receive data word consumes it. A store to the transmit data word hands the low byte to the display side as a one-cycle valid pulse. The transmit side then reports busy until the display returns a done pulse. A character that arrives before software has read the previous one replaces it, and the block records the loss in a sticky flag.

Top module: `term_io_ctrl`

## Requirements
- R1: The page base is 0xFFFF0000. Byte offsets 0x0 (receive control), 0x4 (receive data), 0x8 (transmit control) and 0xC (transmit data) are mapped, and only when the address is word aligned. A read of any other address returns zero one cycle later, and a write to it changes no register.
- R2: Read data is registered. It appears on `bus_rdata` in the cycle after the read strobe is sampled, and it is zero in any cycle that follows no read. Receive control reads as bit 0 = ready, bit 1 = interrupt enable, bit 2 = overrun, with all other bits zero. Transmit control reads as bit 0 = ready, bit 1 = interrupt enable, with all other bits zero.
- R3: A sampled `kbd_valid` stores `kbd_byte` and sets receive ready, visible from the next cycle.
- R4: A read of receive data returns the held character in bits 7:0 with bits 31:8 zero, and clears receive ready. Reading again returns the same character and leaves ready at 0.
- R5: When a character arrives while receive ready is 1 and no receive-data read happens in the same cycle, the new byte replaces the old one, ready stays 1 and the overrun bit is set. A read of receive control returns the overrun bit and then clears it.
- R6: A store to transmit data while transmit ready is 1 raises `disp_valid` for exactly one cycle in the next cycle, with `disp_byte` equal to write data bits 7:0, and clears transmit ready.
- R7: Transmit ready reads 1 again from the cycle after `disp_done` is sampled.
- R8: A store to transmit data while transmit ready is 0 is ignored: no `disp_valid` pulse, and `disp_byte` and transmit ready are unchanged.
- R9: Write data bit 1 sets the interrupt enable bit of the control register being written. Write data bits 0 and 2 have no effect on ready or overrun.
- R10: `irq` equals (receive enable AND receive ready) OR (transmit enable AND transmit ready) in every cycle. It falls as soon as the qualifying ready bit clears.
- R11: After reset, receive ready, overrun and both enable bits are 0, transmit ready is 1, and `irq`, `disp_valid` and `bus_rdata` are 0.
- R12: When a receive-data read and a character arrival fall in the same cycle, the read returns the old character, the new character is kept, ready stays 1 and overrun is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Load strobe, one cycle per access |
| bus_wr | input | 1 | Store strobe, one cycle per access |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Registered load data |
| kbd_valid | input | 1 | Keyboard character strobe |
| kbd_byte | input | 8 | Keyboard character |
| disp_valid | output | 1 | One-cycle pulse: character for the display |
| disp_byte | output | 8 | Character for the display |
| disp_done | input | 1 | Display has finished the last character |
| irq | output | 1 | Level interrupt request |

## Verification
A bound checker tests the cycle-level rules on every cycle:
- the interrupt equation against the flag registers;
- ready rising after a keyboard strobe or a done pulse;
- ready falling after a consuming access;
- the shape and byte of the display pulse;
- zero data for unmapped reads;
- the reset state.

Only the bench scenarios show the rest, because each needs a sequence of accesses and data values:
- overrun, and its clear-on-read;
- the same-cycle read-and-arrival ordering;
- stores ignored while the transmitter is busy;
- writes to read-only bit positions;
- writes outside the page that leave state untouched.

// File: rtl/term_io_pkg.sv
package term_io_pkg;

  // Register selected by the current bus address
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RX_CTRL,
    SEL_RX_DATA,
    SEL_TX_CTRL,
    SEL_TX_DATA
  } reg_sel_e;

  // Word index inside the page; software depends on this order
  localparam logic [1:0] IDX_RX_CTRL = 2'd0;
  localparam logic [1:0] IDX_RX_DATA = 2'd1;
  localparam logic [1:0] IDX_TX_CTRL = 2'd2;
  localparam logic [1:0] IDX_TX_DATA = 2'd3;

  // Control word bit positions
  localparam int BIT_READY = 0;
  localparam int BIT_IE    = 1;
  localparam int BIT_OVR   = 2;

endpackage

// File: rtl/term_bus_decode.sv
module term_bus_decode
  import term_io_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              PAGE_BITS = 12,
  parameter logic [ADDR_W-1:0] PAGE_BASE = 32'hFFFF_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  localparam int HI_W = ADDR_W - PAGE_BITS;

  logic in_page;
  logic low_window;

  assign in_page    = (addr[ADDR_W-1:PAGE_BITS] == PAGE_BASE[ADDR_W-1:PAGE_BITS]);
  // Only the first four aligned words of the page are mapped
  assign low_window = (addr[PAGE_BITS-1:4] == '0) && (addr[1:0] == 2'b00);

  always_comb begin
    sel = SEL_NONE;
    if (in_page && low_window) begin
      unique case (addr[3:2])
        IDX_RX_CTRL: sel = SEL_RX_CTRL;
        IDX_RX_DATA: sel = SEL_RX_DATA;
        IDX_TX_CTRL: sel = SEL_TX_CTRL;
        IDX_TX_DATA: sel = SEL_TX_DATA;
        default:     sel = SEL_NONE;
      endcase
    end
  end

  // HI_W is kept for readers of the decode width
  if (HI_W < 1) begin : g_bad_width
    initial $error("page must be smaller than the address space");
  end

endmodule

// File: rtl/term_rx_chan.sv
module term_rx_chan #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kbd_valid,
  input  logic [CHAR_W-1:0] kbd_byte,
  input  logic              data_rd,
  input  logic              ctrl_rd,
  input  logic              ctrl_wr,
  input  logic              ie_in,
  output logic              ready,
  output logic              ie,
  output logic              overrun,
  output logic [CHAR_W-1:0] data
);

  logic lose;

  // An arrival destroys an unread character unless it is being read now
  assign lose = kbd_valid && ready && !data_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready   <= 1'b0;
      ie      <= 1'b0;
      overrun <= 1'b0;
      data    <= '0;
    end else begin
      if (kbd_valid) begin
        ready <= 1'b1;
        data  <= kbd_byte;
      end else if (data_rd) begin
        ready <= 1'b0;
      end

      if (lose)         overrun <= 1'b1;
      else if (ctrl_rd) overrun <= 1'b0;

      if (ctrl_wr) ie <= ie_in;
    end
  end

endmodule

// File: rtl/term_tx_chan.sv
module term_tx_chan #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_wr,
  input  logic [CHAR_W-1:0] wr_byte,
  input  logic              ctrl_wr,
  input  logic              ie_in,
  input  logic              disp_done,
  output logic              ready,
  output logic              ie,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_byte
);

  logic accept;

  assign accept = data_wr && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready      <= 1'b1;
      ie         <= 1'b0;
      disp_valid <= 1'b0;
      disp_byte  <= '0;
    end else begin
      disp_valid <= accept;
      if (accept) begin
        disp_byte <= wr_byte;
        ready     <= 1'b0;
      end else if (disp_done) begin
        ready <= 1'b1;
      end

      if (ctrl_wr) ie <= ie_in;
    end
  end

endmodule

// File: rtl/term_io_ctrl.sv
module term_io_ctrl
  import term_io_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                BUS_W     = 32,
  parameter int                CHAR_W    = 8,
  parameter int                PAGE_BITS = 12,
  parameter logic [ADDR_W-1:0] PAGE_BASE = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              kbd_valid,
  input  logic [CHAR_W-1:0] kbd_byte,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_byte,
  input  logic              disp_done,
  output logic              irq
);

  localparam int CTRL_W = BIT_OVR + 1;

  reg_sel_e          sel;
  logic              rx_ready, rx_ie, rx_ovr;
  logic              tx_ready, tx_ie;
  logic [CHAR_W-1:0] rx_data;
  logic [BUS_W-1:0]  rx_ctrl_word, tx_ctrl_word, rx_data_word, rd_mux;

  term_bus_decode #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .PAGE_BASE(PAGE_BASE)
  ) u_decode (
    .addr(bus_addr),
    .sel (sel)
  );

  term_rx_chan #(.CHAR_W(CHAR_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .kbd_valid(kbd_valid),
    .kbd_byte (kbd_byte),
    .data_rd  (bus_rd && sel == SEL_RX_DATA),
    .ctrl_rd  (bus_rd && sel == SEL_RX_CTRL),
    .ctrl_wr  (bus_wr && sel == SEL_RX_CTRL),
    .ie_in    (bus_wdata[BIT_IE]),
    .ready    (rx_ready),
    .ie       (rx_ie),
    .overrun  (rx_ovr),
    .data     (rx_data)
  );

  term_tx_chan #(.CHAR_W(CHAR_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .data_wr   (bus_wr && sel == SEL_TX_DATA),
    .wr_byte   (bus_wdata[CHAR_W-1:0]),
    .ctrl_wr   (bus_wr && sel == SEL_TX_CTRL),
    .ie_in     (bus_wdata[BIT_IE]),
    .disp_done (disp_done),
    .ready     (tx_ready),
    .ie        (tx_ie),
    .disp_valid(disp_valid),
    .disp_byte (disp_byte)
  );

  // Word images, zero-extended to the bus width
  always_comb begin
    rx_ctrl_word = '0;
    rx_ctrl_word[BIT_READY] = rx_ready;
    rx_ctrl_word[BIT_IE]    = rx_ie;
    rx_ctrl_word[BIT_OVR]   = rx_ovr;
    tx_ctrl_word = '0;
    tx_ctrl_word[BIT_READY] = tx_ready;
    tx_ctrl_word[BIT_IE]    = tx_ie;
    rx_data_word = '0;
    rx_data_word[CHAR_W-1:0] = rx_data;
  end

  always_comb begin
    unique case (sel)
      SEL_RX_CTRL: rd_mux = rx_ctrl_word;
      SEL_RX_DATA: rd_mux = rx_data_word;
      SEL_TX_CTRL: rd_mux = tx_ctrl_word;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_rd ? rd_mux : '0;
  end

  assign irq = (rx_ie && rx_ready) || (tx_ie && tx_ready);

  if (CTRL_W > BUS_W) begin : g_bad_bus
    initial $error("bus narrower than control word");
  end

endmodule

// File: rtl/term_io_checker.sv
module term_io_checker #(
  parameter int                ADDR_W    = 32,
  parameter int                BUS_W     = 32,
  parameter int                CHAR_W    = 8,
  parameter int                PAGE_BITS = 12,
  parameter logic [ADDR_W-1:0] PAGE_BASE = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              kbd_valid,
  input logic              disp_valid,
  input logic [CHAR_W-1:0] disp_byte,
  input logic              disp_done,
  input logic              irq,
  input logic              rx_ready,
  input logic              rx_ie,
  input logic              tx_ready,
  input logic              tx_ie
);

  localparam logic [ADDR_W-1:0] A_RXD = PAGE_BASE + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_TXD = PAGE_BASE + ADDR_W'(12);

  logic mapped;
  assign mapped = (bus_addr == PAGE_BASE) || (bus_addr == A_RXD) ||
                  (bus_addr == PAGE_BASE + ADDR_W'(8)) || (bus_addr == A_TXD);

  assert_irq_level_R10: assert property (@(posedge clk) disable iff (rst)
    irq == ((rx_ie && rx_ready) || (tx_ie && tx_ready)));

  assert_rx_set_R3: assert property (@(posedge clk) disable iff (rst)
    kbd_valid |=> rx_ready);

  assert_rx_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_RXD && !kbd_valid) |=> !rx_ready);

  assert_tx_send_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_TXD && tx_ready) |=>
      (disp_valid && !tx_ready && disp_byte == $past(bus_wdata[CHAR_W-1:0])));

  assert_tx_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    disp_valid |=> !disp_valid);

  assert_tx_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_TXD && !tx_ready) |=> (!disp_valid && $stable(disp_byte)));

  assert_tx_done_R7: assert property (@(posedge clk) disable iff (rst)
    disp_done |=> tx_ready);

  assert_unmapped_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !mapped) |=> (bus_rdata == '0));

  assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

  assert_reset_R11: assert property (@(posedge clk)
    rst |=> (!rx_ready && tx_ready && !rx_ie && !tx_ie && !disp_valid && bus_rdata == '0));

endmodule

bind term_io_ctrl term_io_checker #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .CHAR_W(CHAR_W),
  .PAGE_BITS(PAGE_BITS), .PAGE_BASE(PAGE_BASE)
) u_checker (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .kbd_valid(kbd_valid),
  .disp_valid(disp_valid), .disp_byte(disp_byte), .disp_done(disp_done), .irq(irq),
  .rx_ready(rx_ready), .rx_ie(rx_ie), .tx_ready(tx_ready), .tx_ie(tx_ie)
);

// File: tb/test_term_io_ctrl.sv
`timescale 1ns/1ps
module test_term_io_ctrl;

  localparam logic [31:0] A_RXC = 32'hFFFF_0000;
  localparam logic [31:0] A_RXD = 32'hFFFF_0004;
  localparam logic [31:0] A_TXC = 32'hFFFF_0008;
  localparam logic [31:0] A_TXD = 32'hFFFF_000C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        kbd_valid = 1'b0;
  logic [7:0]  kbd_byte = '0;
  logic        disp_valid;
  logic [7:0]  disp_byte;
  logic        disp_done = 1'b0;
  logic        irq;

  int n_cmp = 0, n_bad = 0;
  bit reported = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #2.5 clk = ~clk;

  term_io_ctrl i_term_io_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .kbd_valid(kbd_valid),
    .kbd_byte(kbd_byte), .disp_valid(disp_valid), .disp_byte(disp_byte),
    .disp_done(disp_done), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  // Monitor: compares registered read data with the scoreboard queue
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 32'h1, 32'h0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  // Driver tasks
  task automatic do_read(logic [31:0] a, logic [31:0] exp, string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic do_write(logic [31:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic kbd(logic [7:0] b);
    @(negedge clk); kbd_byte = b; kbd_valid = 1'b1;
    @(negedge clk); kbd_valid = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); disp_done = 1'b1;
    @(negedge clk); disp_done = 1'b0;
  endtask

  task automatic read_and_kbd(logic [7:0] b, logic [31:0] exp, string tag);
    @(negedge clk); bus_addr = A_RXD; bus_rd = 1'b1; kbd_byte = b; kbd_valid = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 1'b0; kbd_valid = 1'b0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state
    check("R11 irq", {31'b0, irq}, 32'h0);
    check("R11 disp_valid", {31'b0, disp_valid}, 32'h0);
    check("R11 rdata", bus_rdata, 32'h0);
    do_read(A_RXC, 32'h0, "R11 rx ctrl");
    do_read(A_TXC, 32'h1, "R11 tx ctrl");

    // Receive path
    kbd(8'h41);
    do_read(A_RXC, 32'h1, "R3 ready set");
    do_read(A_RXD, 32'h41, "R4 data");
    do_read(A_RXC, 32'h0, "R4 ready cleared");
    do_read(A_RXD, 32'h41, "R4 reread");
    do_read(A_RXC, 32'h0, "R4 still clear");
    check("R2 idle rdata", bus_rdata, 32'h0);

    // Overrun
    kbd(8'h11);
    kbd(8'h22);
    do_read(A_RXC, 32'h5, "R5 overrun flagged");
    do_read(A_RXC, 32'h1, "R5 overrun cleared");
    do_read(A_RXD, 32'h22, "R5 newest byte kept");

    // Enable bits and interrupt
    do_write(A_RXC, 32'hFFFF_FFFF);
    do_read(A_RXC, 32'h2, "R9 ie set, ready/ovr untouched");
    check("R10 irq idle", {31'b0, irq}, 32'h0);
    kbd(8'h33);
    check("R10 irq rx", {31'b0, irq}, 32'h1);
    do_read(A_RXD, 32'h33, "R4 data");
    check("R10 irq drop", {31'b0, irq}, 32'h0);
    do_write(A_RXC, 32'h0);
    do_read(A_RXC, 32'h0, "R9 ie cleared");

    // Transmit path
    do_write(A_TXC, 32'h2);
    check("R10 irq tx", {31'b0, irq}, 32'h1);
    do_write(A_TXD, 32'h1234_56A5);
    check("R6 disp_valid", {31'b0, disp_valid}, 32'h1);
    check("R6 disp_byte", {24'b0, disp_byte}, 32'hA5);
    check("R10 irq tx busy", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R6 single pulse", {31'b0, disp_valid}, 32'h0);
    do_read(A_TXC, 32'h2, "R6 tx not ready");
    do_write(A_TXD, 32'h77);
    check("R8 no pulse", {31'b0, disp_valid}, 32'h0);
    check("R8 byte held", {24'b0, disp_byte}, 32'hA5);
    do_read(A_TXC, 32'h2, "R8 still busy");
    done_pulse();
    check("R7 irq after done", {31'b0, irq}, 32'h1);
    do_read(A_TXC, 32'h3, "R7 ready back");
    do_write(A_TXC, 32'h1);
    do_read(A_TXC, 32'h1, "R9 tx ie cleared, ready kept");
    do_write(A_TXC, 32'h2);

    // Unmapped and out-of-page accesses
    do_write(32'hFFFF_0010, 32'hFFFF_FFFF);
    do_read(32'hFFFF_0010, 32'h0, "R1 unmapped read");
    do_read(32'h0000_0004, 32'h0, "R1 outside page");
    do_read(32'hFFFF_0005, 32'h0, "R1 unaligned");
    do_write(32'h0000_0008, 32'h0);
    do_write(32'h0000_000C, 32'h99);
    check("R1 no send outside page", {31'b0, disp_valid}, 32'h0);
    do_read(A_TXC, 32'h3, "R1 tx ctrl untouched");
    do_read(A_RXC, 32'h0, "R1 rx ctrl untouched");

    // Read and arrival in the same cycle
    kbd(8'h44);
    read_and_kbd(8'h5A, 32'h44, "R12 old byte returned");
    do_read(A_RXC, 32'h1, "R12 ready kept, no overrun");
    do_read(A_RXD, 32'h5A, "R12 new byte kept");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) check("scoreboard leftover", exp_q.size(), 32'h0);
    summary();
    $finish;
  end

endmodule